// File: doc/BRIEF.md
# PLL Safe Reprogramming Sequencer

This block changes the divider settings of a pixel-clock PLL without ever letting a half-programmed clock reach the display logic. It owns one 64-bit control/status register that sits behind a 32-bit register port. A caller presents a reference divider, a loop multiplier and an output divider with a one-cycle request. The sequencer then parks the PLL and loads the new values. It waits for lock and hands the clock back. When it finishes it pulses `done`, and `lock_timeout` reports whether lock was ever seen.

Every step is a full read-modify-write of the 64-bit register, carried out as two 32-bit reads followed by two 32-bit writes. Only the bits the step targets change. A separate peek command reads the register and returns the three divider fields without writing anything.

Top module: `pll_reprog_seq`

## Requirements
- R1: Register fields: output divider bits 6:0, loop multiplier bits 29:21, reference divider bits 38:32, lock flag bit 39 (set by the PLL), output select bit 40, load strobe bit 43, bypass bit 44, powerdown bit 45. Every other bit is reserved.
- R2: An accepted update makes exactly nine register writes. In order, they set bypass, clear output select, set powerdown, set the load strobe, write all three divider fields, clear the load strobe, clear powerdown, set output select and clear bypass. Between the seventh and eighth writes the lock flag is polled.
- R3: Each write changes only the bits its step targets. Reserved bits and all other fields are written back with the values just read.
- R4: Each 64-bit access is split into a low-word access at offset 0 and a high-word access at offset 4, low word first. Within a step both reads come before both writes, and a read and a write are never asserted together.
- R5: Polling stops at the first read that shows the lock flag set, and the sequence then continues.
- R6: If `POLL_LIMIT` (default 2000) polls all see the lock flag clear, polling stops. The last two writes are still made, and `lock_timeout` is 1 in the cycle `done` pulses. `lock_timeout` is 0 at `done` when lock was seen, and it holds its value until the next accepted update.
- R7: `busy` is high from the cycle after a request is accepted until the cycle `done` or `peek_valid` pulses. While `busy` is high, update and peek requests are ignored. `done` is a one-cycle pulse with `busy` already low.
- R8: A peek accepted while idle reads the register and makes no writes. It then pulses `peek_valid` for one cycle, with the reference divider, loop multiplier and output divider taken from their R1 positions.
- R9: If an update and a peek are requested in the same idle cycle, the update is taken and the peek is dropped.
- R10: While reset is held low, `busy`, `done`, `lock_timeout`, `peek_valid`, `bus_rd` and `bus_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | One-cycle update request |
| upd_ref_div | input | 7 | New reference divider |
| upd_loop_mul | input | 9 | New loop multiplier |
| upd_out_div | input | 7 | New output divider |
| busy | output | 1 | Sequence or peek in progress; requests refused |
| done | output | 1 | One-cycle pulse at the end of an update |
| lock_timeout | output | 1 | Lock was never seen during the last update |
| peek_req | input | 1 | One-cycle read-back request |
| peek_valid | output | 1 | One-cycle pulse, read-back fields valid |
| peek_ref_div | output | 7 | Read-back reference divider |
| peek_loop_mul | output | 9 | Read-back loop multiplier |
| peek_out_div | output | 7 | Read-back output divider |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_offset | output | 3 | Byte offset of the 32-bit word: 0 low, 4 high |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data for `bus_offset`, valid in the same cycle as `bus_rd` |

## Verification
The assertions assume that the register port answers a read combinationally in the same cycle and never stalls, and that request inputs are clean one-cycle levels sampled at the rising edge. The bench register model meets this by returning the addressed half-word from a plain array. Its stimulus changes requests only at the falling edge. Lock is the only bit the model drives by itself: it rises a programmable number of cycles after powerdown clears, or never, which reaches both the lock path and the timeout path. Because the model ignores the lock bit in write data, comparisons of written words leave out bit 39.

// File: rtl/pll_reprog_pkg.sv
// Package: register layout and per-step field edits for the PLL
// reprogramming sequencer. Assumes a 64-bit register reached through a
// 32-bit port. Bit positions are fixed by the PLL and must not be moved.
package pll_reprog_pkg;

    localparam int REG_W   = 64;
    localparam int BUS_W   = 32;
    localparam int REFD_W  = 7;
    localparam int MUL_W   = 9;
    localparam int OUTD_W  = 7;

    localparam int OUTD_LSB = 0;
    localparam int MUL_LSB  = 21;
    localparam int REFD_LSB = 32;
    localparam int LOCK_BIT = 39;
    localparam int SEL_BIT  = 40;
    localparam int LOAD_BIT = 43;
    localparam int BYP_BIT  = 44;
    localparam int PD_BIT   = 45;

    // Update steps are consecutive so the sequencer advances with +1.
    typedef enum logic [3:0] {
        OP_BYP_ON   = 4'd0,
        OP_SEL_OFF  = 4'd1,
        OP_PD_ON    = 4'd2,
        OP_LOAD_ON  = 4'd3,
        OP_DIVS     = 4'd4,
        OP_LOAD_OFF = 4'd5,
        OP_PD_OFF   = 4'd6,
        OP_POLL     = 4'd7,
        OP_SEL_ON   = 4'd8,
        OP_BYP_OFF  = 4'd9,
        OP_PEEK     = 4'd10
    } pll_op_t;

    // True for steps that only read the register.
    function automatic logic op_read_only(input pll_op_t op);
        return (op == OP_POLL) || (op == OP_PEEK);
    endfunction

    // Return the word with only the step's target bits changed.
    function automatic logic [REG_W-1:0] pll_apply(
        input logic [REG_W-1:0]  w,
        input pll_op_t           op,
        input logic [REFD_W-1:0] rd,
        input logic [MUL_W-1:0]  lm,
        input logic [OUTD_W-1:0] od);
        logic [REG_W-1:0] n;
        n = w;
        case (op)
            OP_BYP_ON:   n[BYP_BIT]  = 1'b1;
            OP_SEL_OFF:  n[SEL_BIT]  = 1'b0;
            OP_PD_ON:    n[PD_BIT]   = 1'b1;
            OP_LOAD_ON:  n[LOAD_BIT] = 1'b1;
            OP_DIVS: begin
                n[REFD_LSB +: REFD_W] = rd;
                n[MUL_LSB  +: MUL_W]  = lm;
                n[OUTD_LSB +: OUTD_W] = od;
            end
            OP_LOAD_OFF: n[LOAD_BIT] = 1'b0;
            OP_PD_OFF:   n[PD_BIT]   = 1'b0;
            OP_SEL_ON:   n[SEL_BIT]  = 1'b1;
            OP_BYP_OFF:  n[BYP_BIT]  = 1'b0;
            default:     n = w;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pll_rmw_engine.sv
// Read-modify-write engine. One start runs a single step: it reads the
// low word and then the high word. For a writing step it then writes the
// low word and then the high word, with only the step's bits changed.
// Assumes bus_rdata is valid in the same cycle as bus_rd and that the
// port never stalls. start is honoured only while the engine is idle.
module pll_rmw_engine
    import pll_reprog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  pll_op_t               op,
    input  logic [REFD_W-1:0]     ref_div,
    input  logic [MUL_W-1:0]      loop_mul,
    input  logic [OUTD_W-1:0]     out_div,
    output logic                  rsp_valid,
    output logic [REG_W-1:0]      rsp_word,
    output logic                  bus_rd,
    output logic                  bus_wr,
    output logic                  bus_hi,
    output logic [BUS_W-1:0]      bus_wdata,
    input  logic [BUS_W-1:0]      bus_rdata
);

    typedef enum logic [2:0] {
        E_IDLE, E_RDLO, E_RDHI, E_WRLO, E_WRHI, E_RSP
    } eng_state_t;

    eng_state_t        state;
    pll_op_t           op_q;
    logic [REFD_W-1:0] ref_q;
    logic [MUL_W-1:0]  mul_q;
    logic [OUTD_W-1:0] out_q;
    logic [REG_W-1:0]  word_q;
    logic [REG_W-1:0]  new_word;

    // Step the access sequence and capture both halves of the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= E_IDLE;
            op_q   <= OP_PEEK;
            ref_q  <= '0;
            mul_q  <= '0;
            out_q  <= '0;
            word_q <= '0;
        end else begin
            case (state)
                E_IDLE: if (start) begin
                    op_q  <= op;
                    ref_q <= ref_div;
                    mul_q <= loop_mul;
                    out_q <= out_div;
                    state <= E_RDLO;
                end
                E_RDLO: begin
                    word_q[BUS_W-1:0] <= bus_rdata;
                    state <= E_RDHI;
                end
                E_RDHI: begin
                    word_q[REG_W-1:BUS_W] <= bus_rdata;
                    state <= op_read_only(op_q) ? E_RSP : E_WRLO;
                end
                E_WRLO:  state <= E_WRHI;
                E_WRHI:  state <= E_RSP;
                default: state <= E_IDLE;
            endcase
        end
    end

    // Form the modified word and the bus strobes from the state.
    always_comb begin
        new_word  = pll_apply(word_q, op_q, ref_q, mul_q, out_q);
        bus_rd    = (state == E_RDLO) || (state == E_RDHI);
        bus_wr    = (state == E_WRLO) || (state == E_WRHI);
        bus_hi    = (state == E_RDHI) || (state == E_WRHI);
        bus_wdata = (state == E_WRHI) ? new_word[REG_W-1:BUS_W]
                                      : new_word[BUS_W-1:0];
        rsp_valid = (state == E_RSP);
        rsp_word  = word_q;
    end

endmodule

// File: rtl/pll_step_ctrl.sv
// Step controller. It accepts update and peek requests while idle (an
// update wins a tie) and issues the step list to the engine one step at
// a time. It polls for lock up to POLL_LIMIT times and reports done,
// timeout and read-back results. Assumes the engine answers each start
// with exactly one rsp_valid.
module pll_step_ctrl
    import pll_reprog_pkg::*;
#(
    parameter int POLL_LIMIT = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [REFD_W-1:0] upd_ref_div,
    input  logic [MUL_W-1:0]  upd_loop_mul,
    input  logic [OUTD_W-1:0] upd_out_div,
    input  logic              peek_req,
    output logic              eng_start,
    output pll_op_t           eng_op,
    output logic [REFD_W-1:0] eng_ref_div,
    output logic [MUL_W-1:0]  eng_loop_mul,
    output logic [OUTD_W-1:0] eng_out_div,
    input  logic              eng_rsp_valid,
    input  logic [REG_W-1:0]  eng_rsp_word,
    output logic              busy,
    output logic              done,
    output logic              lock_timeout,
    output logic              peek_valid,
    output logic [REFD_W-1:0] peek_ref_div,
    output logic [MUL_W-1:0]  peek_loop_mul,
    output logic [OUTD_W-1:0] peek_out_div
);

    localparam int PCNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(POLL_LIMIT - 1);

    typedef enum logic [1:0] { C_IDLE, C_ISSUE, C_WAIT } ctl_state_t;

    ctl_state_t        state;
    pll_op_t           op_q;
    logic              is_peek;
    logic              to_pend;
    logic [PCNT_W-1:0] poll_cnt;
    logic              locked_seen;

    assign locked_seen = eng_rsp_word[LOCK_BIT];

    // Accept requests, walk the step list and collect the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= C_IDLE;
            op_q          <= OP_PEEK;
            is_peek       <= 1'b0;
            to_pend       <= 1'b0;
            poll_cnt      <= '0;
            eng_ref_div   <= '0;
            eng_loop_mul  <= '0;
            eng_out_div   <= '0;
            done          <= 1'b0;
            lock_timeout  <= 1'b0;
            peek_valid    <= 1'b0;
            peek_ref_div  <= '0;
            peek_loop_mul <= '0;
            peek_out_div  <= '0;
        end else begin
            done       <= 1'b0;
            peek_valid <= 1'b0;
            case (state)
                C_IDLE: begin
                    if (upd_valid) begin
                        eng_ref_div  <= upd_ref_div;
                        eng_loop_mul <= upd_loop_mul;
                        eng_out_div  <= upd_out_div;
                        op_q         <= OP_BYP_ON;
                        is_peek      <= 1'b0;
                        to_pend      <= 1'b0;
                        poll_cnt     <= '0;
                        lock_timeout <= 1'b0;
                        state        <= C_ISSUE;
                    end else if (peek_req) begin
                        op_q    <= OP_PEEK;
                        is_peek <= 1'b1;
                        state   <= C_ISSUE;
                    end
                end
                C_ISSUE: state <= C_WAIT;
                default: if (eng_rsp_valid) begin
                    if (is_peek) begin
                        peek_ref_div  <= eng_rsp_word[REFD_LSB +: REFD_W];
                        peek_loop_mul <= eng_rsp_word[MUL_LSB  +: MUL_W];
                        peek_out_div  <= eng_rsp_word[OUTD_LSB +: OUTD_W];
                        peek_valid    <= 1'b1;
                        state         <= C_IDLE;
                    end else if (op_q == OP_POLL && !locked_seen
                                 && poll_cnt != PCNT_LAST) begin
                        poll_cnt <= poll_cnt + 1'b1;
                        state    <= C_ISSUE;
                    end else if (op_q == OP_BYP_OFF) begin
                        done         <= 1'b1;
                        lock_timeout <= to_pend;
                        state        <= C_IDLE;
                    end else begin
                        if (op_q == OP_POLL && !locked_seen) to_pend <= 1'b1;
                        op_q  <= pll_op_t'(op_q + 4'd1);
                        state <= C_ISSUE;
                    end
                end
            endcase
        end
    end

    assign eng_start = (state == C_ISSUE);
    assign eng_op    = op_q;
    assign busy      = (state != C_IDLE);

endmodule

// File: rtl/pll_reprog_seq.sv
// Top of the PLL reprogramming sequencer: the step controller drives the
// read-modify-write engine, and the engine drives the 32-bit register
// port. Assumes one register, reached at byte offsets 0 and 4.
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter int POLL_LIMIT = 2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_valid,
    input  logic [6:0]  upd_ref_div,
    input  logic [8:0]  upd_loop_mul,
    input  logic [6:0]  upd_out_div,
    output logic        busy,
    output logic        done,
    output logic        lock_timeout,
    input  logic        peek_req,
    output logic        peek_valid,
    output logic [6:0]  peek_ref_div,
    output logic [8:0]  peek_loop_mul,
    output logic [6:0]  peek_out_div,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [2:0]  bus_offset,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata
);

    logic              eng_start;
    pll_op_t           eng_op;
    logic [REFD_W-1:0] eng_ref_div;
    logic [MUL_W-1:0]  eng_loop_mul;
    logic [OUTD_W-1:0] eng_out_div;
    logic              eng_rsp_valid;
    logic [REG_W-1:0]  eng_rsp_word;
    logic              bus_hi;

    pll_step_ctrl #(.POLL_LIMIT(POLL_LIMIT)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_valid     (upd_valid),
        .upd_ref_div   (upd_ref_div),
        .upd_loop_mul  (upd_loop_mul),
        .upd_out_div   (upd_out_div),
        .peek_req      (peek_req),
        .eng_start     (eng_start),
        .eng_op        (eng_op),
        .eng_ref_div   (eng_ref_div),
        .eng_loop_mul  (eng_loop_mul),
        .eng_out_div   (eng_out_div),
        .eng_rsp_valid (eng_rsp_valid),
        .eng_rsp_word  (eng_rsp_word),
        .busy          (busy),
        .done          (done),
        .lock_timeout  (lock_timeout),
        .peek_valid    (peek_valid),
        .peek_ref_div  (peek_ref_div),
        .peek_loop_mul (peek_loop_mul),
        .peek_out_div  (peek_out_div)
    );

    pll_rmw_engine eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .op        (eng_op),
        .ref_div   (eng_ref_div),
        .loop_mul  (eng_loop_mul),
        .out_div   (eng_out_div),
        .rsp_valid (eng_rsp_valid),
        .rsp_word  (eng_rsp_word),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_hi    (bus_hi),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    assign bus_offset = {bus_hi, 2'b00};

endmodule

// File: rtl/pll_reprog_seq_chk.sv
// Checker for pll_reprog_seq, attached by bind. It watches only the
// ports, and it assumes a register port that answers without stalling.
module pll_reprog_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       lock_timeout,
    input logic       peek_valid,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [2:0] bus_offset
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R4
    AST_OFFSET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_offset == 3'd0 || bus_offset == 3'd4)); // R4
    AST_RD_LO_THEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_offset == 3'd0) |=> (bus_rd && bus_offset == 3'd4)); // R4
    AST_WR_LO_THEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_offset == 3'd0) |=> (bus_wr && bus_offset == 3'd4)); // R4
    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> busy); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_PEEK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        peek_valid |=> !peek_valid); // R8
    AST_PEEK_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(peek_valid && done)); // R8
    AST_TIMEOUT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_timeout) |-> done); // R6
    AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$rose(busy) && !done) |-> $stable(lock_timeout)); // R6

endmodule

bind pll_reprog_seq pll_reprog_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .lock_timeout (lock_timeout),
    .peek_valid   (peek_valid),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_offset   (bus_offset)
);

// File: tb/pll_reprog_seq_tb_top.sv
// Bench: register model with a lock flag that rises a set number of
// cycles after powerdown clears. A table of updates is walked, then
// directed tests cover reset, refusal while busy and request priority.
module pll_reprog_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [63:0] MODEL_INIT = 64'h9C3A_11D5_C01F_FF80;
    localparam logic [63:0] NOLOCK     = ~(64'd1 << 39);
    localparam logic [63:0] RSV_MASK   = ~(64'h7F | (64'h1FF << 21) | (64'h7F << 32)
                                          | (64'd1 << 39) | (64'd1 << 40)
                                          | (64'd1 << 43) | (64'd1 << 44)
                                          | (64'd1 << 45));
    localparam int unsigned NEVER = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [6:0]  r;
        logic [8:0]  m;
        logic [6:0]  o;
        logic [31:0] dly;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{7'd3,   9'd49,  7'd11,  32'd0},
        '{7'd5,   9'd78,  7'd11,  32'd20},
        '{7'd4,   9'd58,  7'd8,   32'd200},
        '{7'd5,   9'd151, 7'd10,  32'hFFFF_FFFF},
        '{7'd127, 9'd511, 7'd127, 32'd3},
        '{7'd0,   9'd0,   7'd0,   32'd1},
        '{7'd4,   9'd95,  7'd8,   32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [6:0]  upd_ref_div = '0;
    logic [8:0]  upd_loop_mul = '0;
    logic [6:0]  upd_out_div = '0;
    logic        peek_req = 1'b0;
    logic        busy, done, lock_timeout, peek_valid;
    logic [6:0]  peek_ref_div, peek_out_div;
    logic [8:0]  peek_loop_mul;
    logic        bus_rd, bus_wr;
    logic [2:0]  bus_offset;
    logic [31:0] bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // register model state
    logic [63:0] mreg = MODEL_INIT;
    int unsigned lock_delay = 0;
    int unsigned lock_cnt = 0;
    logic [63:0] wlog [512];
    int          rlog [512];
    int          wn = 0;
    int          rd_since = 0;
    int          ord_err = 0;
    int          last_kind = 0; // 0 none,1 rdlo,2 rdhi,3 wrlo,4 wrhi
    int          done_cnt = 0;
    logic        to_at_done = 1'b0;
    int          peek_cnt = 0;
    logic [63:0] exp_cur = MODEL_INIT;

    pll_reprog_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_ref_div(upd_ref_div),
        .upd_loop_mul(upd_loop_mul), .upd_out_div(upd_out_div),
        .busy(busy), .done(done), .lock_timeout(lock_timeout),
        .peek_req(peek_req), .peek_valid(peek_valid),
        .peek_ref_div(peek_ref_div), .peek_loop_mul(peek_loop_mul),
        .peek_out_div(peek_out_div),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_offset(bus_offset),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_rdata = (bus_offset == 3'd4) ? mreg[63:32] : mreg[31:0];

    // Register model: writes, lock flag, access log, order check.
    always @(posedge clk) begin
        logic [63:0] nv;
        int kind;
        nv = mreg;
        kind = 0;
        if (bus_rd) kind = (bus_offset == 3'd4) ? 2 : 1;
        if (bus_wr) kind = (bus_offset == 3'd4) ? 4 : 3;
        if (kind != 0) begin
            if (kind == 1 && !(last_kind == 0 || last_kind == 2 || last_kind == 4)) ord_err++;
            if (kind == 2 && last_kind != 1) ord_err++;
            if (kind == 3 && last_kind != 2) ord_err++;
            if (kind == 4 && last_kind != 3) ord_err++;
            if (bus_offset != 3'd0 && bus_offset != 3'd4) ord_err++;
            last_kind = kind;
        end
        if (bus_wr) begin
            if (bus_offset == 3'd4) nv[63:32] = bus_wdata;
            else nv[31:0] = bus_wdata;
        end
        if (nv[45]) begin
            lock_cnt = 0;
            nv[39] = 1'b0;
        end else begin
            if (lock_cnt != NEVER) lock_cnt++;
            nv[39] = (lock_cnt > lock_delay);
        end
        if (bus_rd && bus_offset == 3'd4) rd_since++;
        if (bus_wr && bus_offset == 3'd4) begin
            wlog[wn] = nv;
            rlog[wn] = rd_since;
            rd_since = 0;
            wn++;
        end
        mreg <= nv;
    end

    // Output monitors sampled between edges.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && done) begin
            done_cnt++;
            to_at_done = lock_timeout;
        end
        if (rst_n && peek_valid) peek_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    function automatic logic [63:0] step_val(input logic [63:0] w, input int s,
                                             input logic [6:0] r,
                                             input logic [8:0] m,
                                             input logic [6:0] o);
        logic [63:0] n;
        n = w;
        case (s)
            0: n[44] = 1'b1;
            1: n[40] = 1'b0;
            2: n[45] = 1'b1;
            3: n[43] = 1'b1;
            4: begin n[38:32] = r; n[29:21] = m; n[6:0] = o; end
            5: n[43] = 1'b0;
            6: n[45] = 1'b0;
            7: n[40] = 1'b1;
            default: n[44] = 1'b0;
        endcase
        return n;
    endfunction

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
    endtask

    // R1 R2 R3: check the nine writes of one update against the chain.
    task automatic check_writes(input int base, input logic [6:0] r,
                                input logic [8:0] m, input logic [6:0] o);
        logic [63:0] e;
        e = exp_cur;
        chk(wn - base == 9, "R2 write count", 64'(wn - base), 64'd9);
        for (int s = 0; s < 9; s++) begin
            e = step_val(e, s, r, m, o);
            chk((wlog[base+s] & NOLOCK) == (e & NOLOCK),
                $sformatf("R2 R3 step %0d word", s), wlog[base+s] & NOLOCK, e & NOLOCK);
        end
        chk((wlog[base+8] & RSV_MASK) == (MODEL_INIT & RSV_MASK), "R3 reserved bits",
            wlog[base+8] & RSV_MASK, MODEL_INIT & RSV_MASK);
        exp_cur = e;
    endtask

    task automatic do_peek(input logic [6:0] r, input logic [8:0] m, input logic [6:0] o);
        int pc0, wn0;
        pc0 = peek_cnt;
        wn0 = wn;
        @(negedge clk);
        peek_req = 1'b1;
        @(negedge clk);
        peek_req = 1'b0;
        while (peek_cnt == pc0) @(negedge clk);
        chk(peek_ref_div == r && peek_loop_mul == m && peek_out_div == o,
            "R8 R1 peek fields", {41'd0, peek_ref_div, peek_loop_mul, peek_out_div},
            {41'd0, r, m, o});
        chk(wn == wn0, "R8 peek makes no write", 64'(wn - wn0), 64'd0);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !lock_timeout && !peek_valid && !bus_rd && !bus_wr,
            "R10 reset outputs", {58'd0, busy, done, lock_timeout, peek_valid, bus_rd, bus_wr},
            64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_rd && !bus_wr, "R10 idle after reset",
            {61'd0, busy, bus_rd, bus_wr}, 64'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            int base, d0;
            logic exp_to;
            base = wn;
            d0 = done_cnt;
            lock_delay = VECS[i].dly;
            exp_to = (VECS[i].dly == NEVER);
            upd_valid = 1'b1;
            upd_ref_div = VECS[i].r;
            upd_loop_mul = VECS[i].m;
            upd_out_div = VECS[i].o;
            @(negedge clk);
            upd_valid = 1'b0;
            chk(busy, "R7 busy after accept", {63'd0, busy}, 64'd1);
            wait_done(d0 + 1);
            check_writes(base, VECS[i].r, VECS[i].m, VECS[i].o);
            chk(to_at_done == exp_to, "R6 R5 lock_timeout at done",
                {63'd0, to_at_done}, {63'd0, exp_to});
            if (exp_to)
                chk(rlog[base+7] == 2001, "R6 poll count at timeout",
                    64'(rlog[base+7]), 64'd2001);
            else if (VECS[i].dly == 0)
                chk(rlog[base+7] == 2, "R5 single poll when locked",
                    64'(rlog[base+7]), 64'd2);
            else
                chk(rlog[base+7] >= 2 && rlog[base+7] < 2001, "R5 polling stops at lock",
                    64'(rlog[base+7]), 64'd2);
            @(negedge clk);
            chk(lock_timeout == exp_to, "R6 lock_timeout holds",
                {63'd0, lock_timeout}, {63'd0, exp_to});
            do_peek(VECS[i].r, VECS[i].m, VECS[i].o);
        end

        // R7: requests while busy are refused
        begin
            int base, d0, pc0;
            base = wn;
            d0 = done_cnt;
            pc0 = peek_cnt;
            lock_delay = 10;
            upd_valid = 1'b1;
            upd_ref_div = 7'd3; upd_loop_mul = 9'd50; upd_out_div = 7'd20;
            @(negedge clk);
            upd_valid = 1'b0;
            repeat (6) @(negedge clk);
            upd_valid = 1'b1;
            upd_ref_div = 7'd9; upd_loop_mul = 9'd99; upd_out_div = 7'd9;
            @(negedge clk);
            upd_valid = 1'b0;
            repeat (20) @(negedge clk);
            peek_req = 1'b1;
            @(negedge clk);
            peek_req = 1'b0;
            wait_done(d0 + 1);
            repeat (12) @(negedge clk);
            chk(done_cnt == d0 + 1, "R7 busy request ignored (done count)",
                64'(done_cnt - d0), 64'd1);
            chk(peek_cnt == pc0, "R7 busy peek ignored", 64'(peek_cnt - pc0), 64'd0);
            check_writes(base, 7'd3, 9'd50, 7'd20);
            do_peek(7'd3, 9'd50, 7'd20);
        end

        // R9: update and peek together, update wins
        begin
            int base, d0, pc0;
            base = wn;
            d0 = done_cnt;
            pc0 = peek_cnt;
            lock_delay = 0;
            upd_valid = 1'b1;
            peek_req = 1'b1;
            upd_ref_div = 7'd6; upd_loop_mul = 9'd200; upd_out_div = 7'd33;
            @(negedge clk);
            upd_valid = 1'b0;
            peek_req = 1'b0;
            wait_done(d0 + 1);
            repeat (12) @(negedge clk);
            chk(peek_cnt == pc0, "R9 peek dropped on tie", 64'(peek_cnt - pc0), 64'd0);
            check_writes(base, 7'd6, 9'd200, 7'd33);
        end

        chk(ord_err == 0, "R4 access order and offsets", 64'(ord_err), 64'd0);
        finish_run();
    end

endmodule